// File: doc/BRIEF.md
# Dual-channel ADC serial output emulator

This block stands in for the digital face of a two-converter, simultaneous-sampling analog-to-digital converter. A falling edge on the active-low convert-start input starts both conversions together. The block holds `busy` high for a fixed, parameterised number of system clocks. When that time ends it captures the two sample words presented on its input ports as the conversion results.

Each converter owns one serial data output, modelled as a data bit plus an output-enable. An active-low chip select frames a read. While chip select is low the outputs are driven, and the most significant bit is presented before any serial clock activity. Each later serial-clock falling edge moves both outputs to the next lower bit. If the read runs for a second word length, each pin goes on to carry the other converter's result, so one pin can return both words. Chip select may also be pulled low during a conversion, or held low permanently. In both cases the MSB appears when `busy` falls.

All control inputs are sampled on the system clock `clk`. They are expected to be synchronous to it, or already brought into its domain. The result width is 12 or 14 bits.

Top module: `dual_adc_serial_emu`

## Requirements
- R1: A high-to-low transition of `cnv_n` while `busy` is low raises `busy` at the next `clk` edge. `busy` then stays high for exactly `CONV_CYCLES` clock cycles.
- R2: A falling edge of `cnv_n` while `busy` is high is ignored, and the busy period is not lengthened.
- R3: When `busy` falls, `samp_a` and `samp_b` are captured as the results. Later changes on those ports do not alter the bits read out.
- R4: `sdo_a_oe` and `sdo_b_oe` are 1 exactly while `cs_n` is 0, without waiting for a clock edge.
- R5: One clock after `cs_n` is seen falling, with `busy` low, `sdo_a` shows bit W-1 of result A and `sdo_b` shows bit W-1 of result B.
- R6: Each `sclk` high-to-low transition sampled while `cs_n` is low and `busy` is low moves both outputs one bit toward the LSB, one clock later. The order is MSB first.
- R7: An `sclk` falling edge sampled in the same clock as the `cs_n` falling edge does not advance the bit position. The next `sclk` falling edge yields bit W-2.
- R8: After W advancing edges, `sdo_a` carries result B and `sdo_b` carries result A, each MSB first. After 2*W edges both outputs hold 0.
- R9: Raising `cs_n` ends the read. The next `cs_n` falling edge starts again at the MSB.
- R10: If `cs_n` falls while `busy` is high, the outputs are enabled at once. The first bits after `busy` falls are the new MSBs, whatever `sclk` did during the conversion.
- R11: With `cs_n` held low throughout, the MSBs of the new results appear as `busy` falls. The next bits follow on the first `sclk` falling edge after that.
- R12: After reset, `busy` is 0 and both results are 0.
- R13: `W` must be 12 or 14, and `CONV_CYCLES` must be at least 2. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cnv_n | input | 1 | Active-low convert start; the falling edge begins a conversion |
| cs_n | input | 1 | Active-low chip select framing a read |
| sclk | input | 1 | Serial clock; falling edges step the output bits |
| samp_a | input | W | Sample word for converter A, captured at end of conversion |
| samp_b | input | W | Sample word for converter B, captured at end of conversion |
| busy | output | 1 | High while a conversion is in progress |
| sdo_a | output | 1 | Serial data of pin A (A result, then B) |
| sdo_a_oe | output | 1 | Output enable for pin A |
| sdo_b | output | 1 | Serial data of pin B (B result, then A) |
| sdo_b_oe | output | 1 | Output enable for pin B |

## Verification
A table of word pairs drives full double-length reads. All-ones and all-zeros pairs expose stuck output bits and a missing word hand-over. Alternating patterns show a bit order that is reversed or off by one. Pairs whose A and B words differ show when the chained order on one pin is swapped. A word with only its end bits set confirms where the first and last bits land. Directed cases then cover a serial-clock edge that lands together with chip select, a read cut short and restarted, chip select falling during a conversion with serial-clock edges inside it, chip select held low across a conversion, and a convert-start retrigger while busy.

// File: rtl/adcemu_pkg.sv
package adcemu_pkg;
   localparam int NUM_CH = 2;

   function automatic bit legal_res(input int w);
      return (w == 12) || (w == 14);
   endfunction
endpackage

// File: rtl/adcemu_edge.sv
module adcemu_edge #(
   parameter logic IDLE_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic fall
);
   logic din_q;

   always_ff @(posedge clk) begin
      if (!rst_n) din_q <= IDLE_LVL;
      else        din_q <= din;
   end

   assign fall = din_q & ~din;
endmodule

// File: rtl/adcemu_conv_timer.sv
module adcemu_conv_timer #(
   parameter int W           = 12,
   parameter int NCH         = 2,
   parameter int CONV_CYCLES = 20,
   localparam int CW         = $clog2(CONV_CYCLES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [NCH-1:0][W-1:0]   samp_in,
   output logic                    busy,
   output logic                    done,
   output logic [NCH-1:0][W-1:0]   result
);
   logic [CW-1:0] remain;

   assign done = busy && (remain == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         remain <= '0;
      end else if (!busy) begin
         if (start) begin
            busy   <= 1'b1;
            remain <= CW'(CONV_CYCLES - 1);
         end
      end else if (remain == '0) begin
         busy <= 1'b0;
      end else begin
         remain <= remain - 1'b1;
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_res
      always_ff @(posedge clk) begin
         if (!rst_n)    result[c] <= '0;
         else if (done) result[c] <= samp_in[c];
      end
   end
endmodule

// File: rtl/adcemu_bit_index.sv
module adcemu_bit_index #(
   parameter int W   = 12,
   localparam int LAST = 2 * W,
   localparam int IW   = $clog2(LAST + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reload,
   input  logic          advance,
   output logic [IW-1:0] idx
);
   always_ff @(posedge clk) begin
      if (!rst_n)                               idx <= '0;
      else if (reload)                          idx <= '0;
      else if (advance && (idx != IW'(LAST)))   idx <= idx + 1'b1;
   end
endmodule

// File: rtl/adcemu_serializer.sv
module adcemu_serializer #(
   parameter int W  = 12,
   localparam int IW = $clog2(2 * W + 1)
) (
   input  logic [W-1:0]  first_word,
   input  logic [W-1:0]  second_word,
   input  logic [IW-1:0] idx,
   output logic          bit_out
);
   logic [2*W:0]  stream;
   logic [IW-1:0] pos;

   assign stream  = {first_word, second_word, 1'b0};
   assign pos     = IW'(2 * W) - idx;
   assign bit_out = stream[pos];
endmodule

// File: rtl/dual_adc_serial_emu.sv
module dual_adc_serial_emu #(
   parameter int W           = 12,
   parameter int CONV_CYCLES = 20,
   localparam int NCH        = adcemu_pkg::NUM_CH,
   localparam int IW         = $clog2(2 * W + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cnv_n,
   input  logic         cs_n,
   input  logic         sclk,
   input  logic [W-1:0] samp_a,
   input  logic [W-1:0] samp_b,
   output logic         busy,
   output logic         sdo_a,
   output logic         sdo_a_oe,
   output logic         sdo_b,
   output logic         sdo_b_oe
);
   // R13 parameter legality
   if (!adcemu_pkg::legal_res(W)) begin : g_bad_res
      $error("dual_adc_serial_emu: W must be 12 or 14");
   end
   if (CONV_CYCLES < 2) begin : g_bad_conv
      $error("dual_adc_serial_emu: CONV_CYCLES must be at least 2");
   end

   logic cnv_fall, cs_fall, sclk_fall;
   logic conv_done;
   logic [IW-1:0] bit_idx;
   logic [NCH-1:0][W-1:0] samp_bus, word_bus;
   logic [NCH-1:0] sdo_bus;

   adcemu_edge #(.IDLE_LVL(1'b0)) u_cnv_edge (
      .clk(clk), .rst_n(rst_n), .din(cnv_n), .fall(cnv_fall));
   adcemu_edge #(.IDLE_LVL(1'b0)) u_cs_edge (
      .clk(clk), .rst_n(rst_n), .din(cs_n), .fall(cs_fall));
   adcemu_edge #(.IDLE_LVL(1'b0)) u_sclk_edge (
      .clk(clk), .rst_n(rst_n), .din(sclk), .fall(sclk_fall));

   assign samp_bus[0] = samp_a;
   assign samp_bus[1] = samp_b;

   adcemu_conv_timer #(.W(W), .NCH(NCH), .CONV_CYCLES(CONV_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(cnv_fall), .samp_in(samp_bus),
      .busy(busy), .done(conv_done), .result(word_bus));

   adcemu_bit_index #(.W(W)) u_index (
      .clk(clk), .rst_n(rst_n),
      .reload(conv_done | cs_fall),
      .advance(sclk_fall & ~cs_n & ~busy),
      .idx(bit_idx));

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      adcemu_serializer #(.W(W)) u_ser (
         .first_word(word_bus[c]),
         .second_word(word_bus[NCH-1-c]),
         .idx(bit_idx),
         .bit_out(sdo_bus[c]));
   end

   assign sdo_a    = sdo_bus[0];
   assign sdo_b    = sdo_bus[1];
   assign sdo_a_oe = ~cs_n;
   assign sdo_b_oe = ~cs_n;
endmodule

// File: rtl/adcemu_chk.sv
module adcemu_chk #(
   parameter int W           = 12,
   parameter int CONV_CYCLES = 20,
   localparam int IW         = $clog2(2 * W + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_n,
   input logic          busy,
   input logic          cnv_fall,
   input logic          cs_fall,
   input logic          sclk_fall,
   input logic          conv_done,
   input logic [IW-1:0] bit_idx,
   input logic [W-1:0]  samp_a,
   input logic [W-1:0]  samp_b,
   input logic          sdo_a,
   input logic          sdo_b
);
   int busy_run;

   always_ff @(posedge clk) begin
      if (!rst_n)    busy_run <= 0;
      else if (busy) busy_run <= busy_run + 1;
      else           busy_run <= 0;
   end

   // R1
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnv_fall && !busy) |=> busy);

   // R2
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_run == CONV_CYCLES));

   // R3
   msb_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ((sdo_a == $past(samp_a[W-1])) && (sdo_b == $past(samp_b[W-1]))));

   // R6
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_fall && !cs_n && !cs_fall && !busy && (bit_idx < IW'(2 * W)))
      |=> (bit_idx == $past(bit_idx) + 1'b1));

   // R7
   coincide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_fall && sclk_fall) |=> (bit_idx == '0));

   // R8
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_idx <= IW'(2 * W));

   // R10
   hold_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !conv_done && !cs_fall) |=> $stable(bit_idx));
endmodule

bind dual_adc_serial_emu adcemu_chk #(.W(W), .CONV_CYCLES(CONV_CYCLES)) chk_i (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .busy(busy),
   .cnv_fall(cnv_fall), .cs_fall(cs_fall), .sclk_fall(sclk_fall),
   .conv_done(conv_done), .bit_idx(bit_idx),
   .samp_a(samp_a), .samp_b(samp_b), .sdo_a(sdo_a), .sdo_b(sdo_b));

// File: tb/dual_adc_serial_emu_tb_top.sv
module dual_adc_serial_emu_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int W          = 12;
   localparam int CONV       = 20;
   localparam int NVEC       = 6;

   localparam logic [W-1:0] VEC_A [NVEC] = '{12'hFFF, 12'h000, 12'hA5A, 12'h801, 12'h3C7, 12'h123};
   localparam logic [W-1:0] VEC_B [NVEC] = '{12'hFFF, 12'hFFF, 12'h5A5, 12'h000, 12'hE18, 12'hFED};

   logic clk = 1'b0;
   logic rst_n, cnv_n, cs_n, sclk;
   logic [W-1:0] samp_a, samp_b;
   logic busy, sdo_a, sdo_a_oe, sdo_b, sdo_b_oe;
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dual_adc_serial_emu #(.W(W), .CONV_CYCLES(CONV)) dut_i (
      .clk(clk), .rst_n(rst_n), .cnv_n(cnv_n), .cs_n(cs_n), .sclk(sclk),
      .samp_a(samp_a), .samp_b(samp_b), .busy(busy),
      .sdo_a(sdo_a), .sdo_a_oe(sdo_a_oe), .sdo_b(sdo_b), .sdo_b_oe(sdo_b_oe));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic chain_bit(input logic [W-1:0] f, input logic [W-1:0] s, input int i);
      logic [2*W:0] c;
      c = {f, s, 1'b0};
      return c[2*W-i];
   endfunction

   task automatic sclk_pulse();
      @(negedge clk) sclk = 1'b1;
      @(negedge clk) sclk = 1'b0;
      @(posedge clk) #1;
   endtask

   task automatic cs_fall_now();
      @(negedge clk) cs_n = 1'b0;
      #1;
      chk("R4 oe on", {sdo_a_oe, sdo_b_oe}, 2'b11);
      @(posedge clk) #1;
   endtask

   task automatic cs_rise_now();
      @(negedge clk) cs_n = 1'b1;
      #1;
      chk("R4 oe off", {sdo_a_oe, sdo_b_oe}, 2'b00);
      @(negedge clk);
   endtask

   // mode: 0 plain, 1 retrigger while busy, 2 chip select and sclk edges during busy
   task automatic convert(input logic [W-1:0] a, input logic [W-1:0] b, input int mode);
      int run;
      samp_a = a;
      samp_b = b;
      @(negedge clk) cnv_n = 1'b0;
      @(posedge clk) #1;
      chk("R1 busy rise", busy, 1'b1);
      run = 1;
      for (int cyc = 1; cyc < 1000 && busy; cyc++) begin
         @(negedge clk);
         if (cyc == 1) cnv_n = 1'b1;
         if (mode == 1 && cyc == 3) cnv_n = 1'b0;
         if (mode == 1 && cyc == 5) cnv_n = 1'b1;
         if (mode == 2 && cyc == 2) cs_n = 1'b0;
         if (mode == 2 && (cyc == 4 || cyc == 8)) sclk = 1'b1;
         if (mode == 2 && (cyc == 5 || cyc == 9)) sclk = 1'b0;
         @(posedge clk) #1;
         if (mode == 2 && cyc == 6) chk("R10 oe during busy", sdo_a_oe, 1'b1);
         if (busy) run++;
      end
      chk(mode == 1 ? "R2 busy length after retrigger" : "R1 busy length", run, CONV);
   endtask

   task automatic full_read(input logic [W-1:0] a, input logic [W-1:0] b);
      samp_a = ~a;
      samp_b = ~b;
      cs_fall_now();
      chk("R5 msb a", sdo_a, a[W-1]);
      chk("R5 msb b", sdo_b, b[W-1]);
      for (int i = 1; i <= 2 * W; i++) begin
         sclk_pulse();
         chk(i < W ? "R6 R3 bit a" : "R8 chain a", sdo_a, chain_bit(a, b, i));
         chk(i < W ? "R6 R3 bit b" : "R8 chain b", sdo_b, chain_bit(b, a, i));
      end
      sclk_pulse();
      chk("R8 held zero", {sdo_a, sdo_b}, 2'b00);
      cs_rise_now();
   endtask

   initial begin
      rst_n = 1'b0; cnv_n = 1'b1; cs_n = 1'b1; sclk = 1'b0;
      samp_a = '0; samp_b = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk) #1;

      // R12 reset state
      chk("R12 busy after reset", busy, 1'b0);
      chk("R4 oe idle", {sdo_a_oe, sdo_b_oe}, 2'b00);
      cs_fall_now();
      chk("R12 results zero", {sdo_a, sdo_b}, 2'b00);
      cs_rise_now();

      for (int v = 0; v < NVEC; v++) begin
         convert(VEC_A[v], VEC_B[v], 0);
         full_read(VEC_A[v], VEC_B[v]);
      end

      // R2 retrigger during busy
      convert(12'hC35, 12'h3CA, 1);
      chk("R2 no restart", busy, 1'b0);

      // R7 sclk falling together with cs falling
      @(negedge clk) sclk = 1'b1;
      @(negedge clk) begin cs_n = 1'b0; sclk = 1'b0; end
      @(posedge clk) #1;
      chk("R7 coincident edge ignored a", sdo_a, 1'b1);
      chk("R7 coincident edge ignored b", sdo_b, 1'b0);
      sclk_pulse();
      chk("R7 next edge gives W-2 a", sdo_a, 1'b1);
      chk("R7 next edge gives W-2 b", sdo_b, 1'b0);

      // R9 cut read short, restart at MSB
      sclk_pulse();
      chk("R9 before abort a", sdo_a, 1'b0);
      cs_rise_now();
      cs_fall_now();
      chk("R9 restart msb a", sdo_a, 1'b1);
      chk("R9 restart msb b", sdo_b, 1'b0);
      cs_rise_now();

      // R10 chip select low during conversion with sclk edges inside it
      convert(12'h6F0, 12'h90F, 2);
      chk("R10 msb a after busy", sdo_a, 1'b0);
      chk("R10 msb b after busy", sdo_b, 1'b1);
      sclk_pulse();
      chk("R10 second bit a", sdo_a, 1'b1);
      chk("R10 second bit b", sdo_b, 1'b0);

      // R11 chip select stays low across a new conversion
      convert(12'h8AA, 12'h455, 0);
      chk("R11 oe stays on", {sdo_a_oe, sdo_b_oe}, 2'b11);
      chk("R11 msb a at busy fall", sdo_a, 1'b1);
      chk("R11 msb b at busy fall", sdo_b, 1'b0);
      sclk_pulse();
      chk("R11 next bit a", sdo_a, 1'b0);
      chk("R11 next bit b", sdo_b, 1'b1);
      cs_rise_now();

      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule